// File: doc/BRIEF.md
# Serial CRC-8 Block Check Unit

This unit computes an 8-bit block check over a serial bit stream, one bit per qualified clock. The same generator polynomial, x^7 + x^5 + x^4 + x + 1, is used in both link directions. It is realised as an 8-stage feedback shift register with XOR taps at stages 0, 1, 4, 5 and 7. A frame starts with a clear pulse, which zeroes the register. The payload bits then follow in line order. For a received command these are all command bits except the start bit, most significant first. For a transmitted answer they are all answer bits, first bit sent first.

After the payload, the check phase begins. In receive mode the eight incoming check bits are collected and compared with the computed register. The match flag rises after the last of them. In transmit mode the register itself is shifted out, most significant bit first, on the serial output. The same unit also validates the factory identification word. A 32-bit serial number followed by the 8-bit customer code (0x65 for the standard version) is run through it in receive mode, followed by the stored check byte.

Top module: `crc8_serial_chk`

## Requirements
- R1: After a cycle with `rst_n` low, `crc_o` is 0x00 and `match_o` is 0.
- R2: A cycle with `clear_i` high sets `crc_o` to 0x00 and `match_o` to 0, and restarts check-bit collection. This happens whatever `bit_valid_i` shows in that cycle.
- R3: In a cycle with `bit_valid_i` high and `chk_phase_i` low, in either mode, the register steps on the edge. With f = `bit_i` XOR `crc_o[7]`, the new value is (`crc_o` << 1, zero fill, 8 bits) XOR (f ? 0xB3 : 0x00). 0xB3 has bits 7, 5, 4, 1 and 0 set. From 0x00, a single 1 gives 0xB3, and a following 0 gives 0xD5.
- R4: In a cycle with `bit_valid_i` low and `clear_i` low, `crc_o` and `match_o` keep their values.
- R5: In receive mode (`mode_tx_i` = 0), valid bits with `chk_phase_i` high leave `crc_o` unchanged. They are collected most significant first. On the edge of the eighth such bit, `match_o` takes the value (collected byte == `crc_o`), and it is visible in the following cycle.
- R6: If the eight collected check bits differ from `crc_o`, `match_o` stays 0.
- R7: Check bits after the eighth are ignored until the next clear: `match_o` and `crc_o` do not change.
- R8: `bit_o` always equals `crc_o[7]`. In transmit mode (`mode_tx_i` = 1), each valid bit with `chk_phase_i` high shifts `crc_o` left with zero fill. After eight such shifts `crc_o` is 0x00 and the check byte has appeared on `bit_o`, most significant bit first.
- R9: `match_o` never rises on an edge where the check phase is running in transmit mode.
- R10: Running the serial number (B31 first) and then the customer code 0x65 (bit 7 first) in receive mode, followed by their CRC as check byte, gives `match_o` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear_i | input | 1 | Frame start: zero the register and the compare state |
| mode_tx_i | input | 1 | 1 = transmit (shift check byte out), 0 = receive (compare) |
| chk_phase_i | input | 1 | 1 = current bit belongs to the check byte |
| bit_i | input | 1 | Serial data bit |
| bit_valid_i | input | 1 | Qualifies `bit_i` for this cycle |
| crc_o | output | 8 | Current CRC register |
| bit_o | output | 1 | Serial check-byte output (register MSB) |
| match_o | output | 1 | Received check byte equals computed CRC |

## Verification
The embedded properties check several behaviours on every cycle. They cover clearing, the hold of the register without a valid bit, its freeze during receive check bits, and the zero-fill shift in transmit. They also check that the match flag rises only on the eighth check bit, never in transmit, and stays put once collection is full. Only the bench scenarios can show that the polynomial arithmetic is right and that matching and mismatching check bytes are told apart. The same holds for the serial-number and customer-code check. A behavioural model supplies those values.

// File: rtl/crc8_pkg.sv
// Package: shared constants and types for the serial CRC-8 unit.
// Assumes the generator polynomial x^7+x^5+x^4+x+1 (taps 0,1,4,5,7).
package crc8_pkg;
    localparam int          CRC_W    = 8;
    localparam logic [7:0]  CRC_POLY = 8'hB3;

    typedef enum logic {
        MODE_RX = 1'b0,
        MODE_TX = 1'b1
    } crc_mode_e;
endpackage

// File: rtl/crc8_lfsr.sv
// Module: feedback shift register holding the running CRC.
// step_i divides in one data bit; shift_i moves the register left with
// zero fill (check-byte output). Assumes step_i and shift_i never both high.
module crc8_lfsr #(
    parameter int          W    = 8,
    parameter logic [W-1:0] POLY = 8'hB3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         step_i,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] crc_o
);
    logic [W-1:0] crc_q;
    logic [W-1:0] step_nxt;
    logic         fb;

    // Feedback: incoming bit against the register MSB.
    assign fb = bit_i ^ crc_q[W-1];

    // One XOR tap per stage where the polynomial has a term.
    assign step_nxt[0] = fb & POLY[0];
    for (genvar i = 1; i < W; i++) begin : g_stage
        assign step_nxt[i] = crc_q[i-1] ^ (fb & POLY[i]);
    end

    // Register update: clear has priority, then data step, then shift-out.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            crc_q <= '0;
        end else if (step_i) begin
            crc_q <= step_nxt;
        end else if (shift_i) begin
            crc_q <= {crc_q[W-2:0], 1'b0};
        end
    end

    assign crc_o = crc_q;

    p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (crc_q == '0));

    p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !step_i && !shift_i) |=> $stable(crc_q));

    p_shift_zero_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && shift_i && !step_i) |=> (crc_q[0] == 1'b0));
endmodule

// File: rtl/crc8_rxcmp.sv
// Module: collects the received check byte MSB first and compares it with
// the computed CRC after the last check bit. Extra bits are ignored until
// the next clear. Assumes crc_i is frozen while check bits arrive.
module crc8_rxcmp #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         cap_i,
    input  logic         bit_i,
    input  logic [W-1:0] crc_i,
    output logic         match_o
);
    localparam int            CW   = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W - 1);
    localparam logic [CW-1:0] FULL = CW'(W);

    logic [W-1:0]  cap_q;
    logic [W-1:0]  cap_nxt;
    logic [CW-1:0] cnt_q;
    logic          match_q;

    // Next collected byte with the new bit entering at the LSB.
    assign cap_nxt = {cap_q[W-2:0], bit_i};

    // Collection, count and compare on the final check bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cap_q   <= '0;
            cnt_q   <= '0;
            match_q <= 1'b0;
        end else if (cap_i && (cnt_q != FULL)) begin
            cap_q <= cap_nxt;
            cnt_q <= cnt_q + CW'(1);
            if (cnt_q == LAST) begin
                match_q <= (cap_nxt == crc_i);
            end
        end
    end

    assign match_o = match_q;

    p_match_at_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_q) |-> ($past(cnt_q) == LAST));

    p_match_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_q == FULL) && !clear_i) |=> $stable(match_q));

    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL);
endmodule

// File: rtl/crc8_serial_chk.sv
// Module: top of the serial CRC-8 unit. Routes each valid bit to the data
// step, the transmit shift-out or the receive compare, by phase and mode.
// Assumes the caller pulses clear_i at each frame start.
module crc8_serial_chk
    import crc8_pkg::*;
#(
    parameter int           W    = CRC_W,
    parameter logic [W-1:0] POLY = CRC_POLY
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         mode_tx_i,
    input  logic         chk_phase_i,
    input  logic         bit_i,
    input  logic         bit_valid_i,
    output logic [W-1:0] crc_o,
    output logic         bit_o,
    output logic         match_o
);
    crc_mode_e mode;
    logic      do_step;
    logic      do_shift;
    logic      do_cap;

    // Decode the role of the current bit.
    assign mode     = crc_mode_e'(mode_tx_i);
    assign do_step  = bit_valid_i && !chk_phase_i;
    assign do_shift = bit_valid_i && chk_phase_i && (mode == MODE_TX);
    assign do_cap   = bit_valid_i && chk_phase_i && (mode == MODE_RX);

    crc8_lfsr #(.W(W), .POLY(POLY)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_i),
        .step_i  (do_step),
        .shift_i (do_shift),
        .bit_i   (bit_i),
        .crc_o   (crc_o)
    );

    crc8_rxcmp #(.W(W)) u_rxcmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_i),
        .cap_i   (do_cap),
        .bit_i   (bit_i),
        .crc_i   (crc_o),
        .match_o (match_o)
    );

    // Serial check-byte output is the register MSB.
    assign bit_o = crc_o[W-1];

    p_rx_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && bit_valid_i && chk_phase_i && !mode_tx_i) |=> $stable(crc_o));

    p_no_match_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_o) |-> !$past(chk_phase_i && mode_tx_i));

    p_clear_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !match_o);
endmodule

// File: tb/crc8_serial_chk_test.sv
module crc8_serial_chk_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clear_i = 1'b0;
    logic       mode_tx_i = 1'b0;
    logic       chk_phase_i = 1'b0;
    logic       bit_i = 1'b0;
    logic       bit_valid_i = 1'b0;
    logic [7:0] crc_o;
    logic       bit_o;
    logic       match_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Behavioural reference state.
    int m_crc = 0;
    int m_rx = 0;
    int m_cnt = 0;
    int m_match = 0;

    always #10 clk = ~clk;

    crc8_serial_chk uut (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .mode_tx_i(mode_tx_i),
        .chk_phase_i(chk_phase_i), .bit_i(bit_i), .bit_valid_i(bit_valid_i),
        .crc_o(crc_o), .bit_o(bit_o), .match_o(match_o)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Polynomial long division, one bit at a time, as arithmetic on integers.
    function automatic int div_bit(input int c, input int b);
        int top;
        top = (c >> 7) & 1;
        c = (c * 2) % 256;
        if ((top ^ b) != 0) c = c ^ 'hB3;
        return c;
    endfunction

    // One clock: drive at negedge, advance model, compare at next negedge.
    task automatic cyc(input string tag, input bit clr, input bit v, input bit b,
                       input bit chk, input bit tx);
        clear_i = clr; bit_valid_i = v; bit_i = b; chk_phase_i = chk; mode_tx_i = tx;
        if (clr) begin
            m_crc = 0; m_rx = 0; m_cnt = 0; m_match = 0;
        end else if (v) begin
            if (!chk) m_crc = div_bit(m_crc, b);
            else if (tx) m_crc = (m_crc * 2) % 256;
            else if (m_cnt < 8) begin
                m_rx = (m_rx * 2 + b) % 256;
                m_cnt++;
                if (m_cnt == 8) m_match = (m_rx == m_crc) ? 1 : 0;
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, "crc_o", crc_o, m_crc);
        check(tag, "match_o", match_o, m_match);
        check(tag, "bit_o", bit_o, (m_crc >> 7) & 1);
    endtask

    task automatic send(input string tag, input logic [63:0] val, input int n,
                        input bit chk, input bit tx);
        for (int i = n - 1; i >= 0; i--) cyc(tag, 0, 1, val[i], chk, tx);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int idb;
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1", "crc_o", crc_o, 0);
        check("R1", "match_o", match_o, 0);
        rst_n = 1'b1;

        // R3: hand-computed steps
        cyc("R2", 1, 0, 0, 0, 0);
        cyc("R3", 0, 1, 1, 0, 0);
        check("R3", "crc after 1", crc_o, 'hB3);
        cyc("R3", 0, 1, 0, 0, 0);
        check("R3", "crc after 10", crc_o, 'hD5);
        send("R3", 64'h5A3, 12, 0, 0);

        // R4: idle cycles hold state
        for (int i = 0; i < 4; i++) cyc("R4", 0, 0, i[0], i[1], 0);

        // R2: clear wins over valid
        cyc("R2", 1, 1, 1, 0, 0);
        check("R2", "crc cleared", crc_o, 0);

        // R5/R7: correct receive check byte, then surplus bits
        send("R5", 64'h2C7, 11, 0, 0);
        idb = m_crc;
        send("R5", 64'(idb), 8, 1, 0);
        check("R5", "match good", match_o, 1);
        send("R7", 64'h0F, 6, 1, 0);
        check("R7", "match kept", match_o, 1);

        // R6: wrong check byte
        cyc("R2", 1, 0, 0, 0, 0);
        check("R2", "match cleared", match_o, 0);
        send("R6", 64'h91, 8, 0, 0);
        idb = m_crc ^ 'h04;
        send("R6", 64'(idb), 8, 1, 0);
        check("R6", "match bad", match_o, 0);

        // R8/R9: transmit, shift the check byte out
        cyc("R2", 1, 0, 0, 0, 1);
        send("R8", 64'hBEEF, 16, 0, 1);
        idb = m_crc;
        for (int i = 7; i >= 0; i--) begin
            check("R8", "bit_o serial", bit_o, (idb >> i) & 1);
            cyc("R9", 0, 1, 0, 1, 1);
        end
        check("R8", "crc emptied", crc_o, 0);
        check("R9", "no match in tx", match_o, 0);

        // R10: serial number plus customer code 0x65
        cyc("R2", 1, 0, 0, 0, 0);
        send("R10", 64'h1234ABCD, 32, 0, 0);
        send("R10", 64'h65, 8, 0, 0);
        idb = m_crc;
        send("R10", 64'(idb), 8, 1, 0);
        check("R10", "id match", match_o, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule